// File: doc/BRIEF.md
# Elapsed-Cycle Threshold Checker

This block gives a hardware process its own cycle time base and measures how long a marked region of that process takes. A free-running counter starts at zero after reset and advances on every clock. Its value is written into a stamp register only when the monitored state machine moves to a new state. As a result, every point inside a state that lasts several cycles reports the cycle at which that state was entered.

A start strobe records the current stamp. A later end strobe subtracts the recorded value from the current stamp, giving the elapsed cycles. That one elapsed value is compared against a ladder of upper bounds, up to ten by default. Each bound has its own failure bit, and all bounds are evaluated together. The failure bits that are set therefore show the band in which the worst-case time falls. For example, with a ladder such as 1024, 640, 576, ... a measurement that violates everything except 1024 lies between 640 and 1023 cycles.

The failure bits form a one-cycle pulse. The measured delta is held in a register until the next end strobe.

Top module: `elapsed_ladder_check`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `fail_flags` is all zero and `delta_out` is zero.
- R2: The cycle counter is zero at reset release and increases by one on every clock. A start taken together with a state change in the first cycle after reset records 0, and an end taken together with a state change N cycles later yields a delta of N.
- R3: Start and end read the stamp of the state currently being entered. If `state_chg` is high in the same cycle, they read the counter value of that cycle. Otherwise they read the counter value captured at the most recent `state_chg`, so marks inside a long state all read the entry time.
- R4: The delta is (end stamp − start stamp) modulo 2^CNT_W. A single counter wrap between start and end still gives the true elapsed count.
- R5: Bit i of `fail_flags` is set exactly when the delta is greater than or equal to bound i. Bound i occupies `bounds_flat[i*CNT_W +: CNT_W]`. Every bound is judged independently, so all violated bounds are reported together.
- R6: `fail_flags` and `delta_out` are updated on the clock edge that samples `end_mark`. The flags are nonzero only in the single cycle after an end strobe. `delta_out` keeps its value until the next end strobe.
- R7: When start and end are strobed in the same cycle, the end uses the previously recorded start. The new start applies to the following measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| state_chg | input | 1 | Pulse: the monitored state machine enters a new state this cycle |
| start_mark | input | 1 | Record the current stamp as the start of a measurement |
| end_mark | input | 1 | Close the measurement and compare the delta with all bounds |
| bounds_flat | input | N_BOUNDS*CNT_W | Packed bounds; bound i sits at bits [i*CNT_W +: CNT_W] |
| fail_flags | output | N_BOUNDS | One bit per bound, pulsed for one cycle when delta >= bound |
| delta_out | output | CNT_W | Most recent measured delta in cycles |

## Verification
The bench attacks the ladder edges: deltas equal to a bound, one below it, and one above it. A design that compared with "greater than" instead of "greater or equal", or that stopped after the first violated bound, would set the wrong set of flags.

It also opens and closes measurements inside states that last many cycles. A design that sampled the raw counter instead of the entry stamp would report a different delta.

Two further cases are covered. In the first, start and end fall in the same cycle; a design that let the new start reach the end would report zero. In the second, a measurement straddles a counter wrap; a design that extended or saturated the subtraction would report a huge delta.

// File: rtl/elc_pkg.sv
package elc_pkg;
  localparam int ELC_MAX_W = 64;
  typedef logic [ELC_MAX_W-1:0] elc_word_t;

  // elapsed cycles between two stamps, modulo 2^ELC_MAX_W (truncated by caller)
  function automatic elc_word_t elc_elapsed(elc_word_t t_open, elc_word_t t_close);
    return t_close - t_open;
  endfunction

  // a bound is violated when the elapsed value is not strictly below it
  function automatic logic elc_breach(elc_word_t span, elc_word_t limit);
    return !(span < limit);
  endfunction
endpackage

// File: rtl/elc_timebase.sv
module elc_timebase #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             state_chg,
  output logic [CNT_W-1:0] cyc_now,
  output logic [CNT_W-1:0] stamp_q,
  output logic [CNT_W-1:0] mark_now
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stamp_q <= '0;
    else if (state_chg) stamp_q <= cnt_q;
  end

  assign cyc_now  = cnt_q;
  // a mark in a transition cycle sees the entry time of the new state
  assign mark_now = state_chg ? cnt_q : stamp_q;
endmodule

// File: rtl/elc_span_meas.sv
module elc_span_meas
  import elc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_mark,
  input  logic [CNT_W-1:0] mark_now,
  output logic [CNT_W-1:0] open_q,
  output logic [CNT_W-1:0] span_now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          open_q <= '0;
    else if (start_mark) open_q <= mark_now;
  end

  // uses the start recorded before this cycle, so start+end together closes the old one
  assign span_now = CNT_W'(elc_elapsed(elc_word_t'(open_q), elc_word_t'(mark_now)));
endmodule

// File: rtl/elc_ladder.sv
module elc_ladder
  import elc_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int N_BOUNDS = 10
) (
  input  logic [CNT_W-1:0]          span,
  input  logic [N_BOUNDS*CNT_W-1:0] bounds_flat,
  output logic [N_BOUNDS-1:0]       breach_vec
);
  for (genvar gi = 0; gi < N_BOUNDS; gi++) begin : g_rung
    logic [CNT_W-1:0] limit;
    assign limit          = bounds_flat[gi*CNT_W +: CNT_W];
    assign breach_vec[gi] = elc_breach(elc_word_t'(span), elc_word_t'(limit));
  end
endmodule

// File: rtl/elapsed_ladder_check.sv
module elapsed_ladder_check #(
  parameter int CNT_W    = 64,
  parameter int N_BOUNDS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      state_chg,
  input  logic                      start_mark,
  input  logic                      end_mark,
  input  logic [N_BOUNDS*CNT_W-1:0] bounds_flat,
  output logic [N_BOUNDS-1:0]       fail_flags,
  output logic [CNT_W-1:0]          delta_out
);
  logic [CNT_W-1:0]    cyc_now;
  logic [CNT_W-1:0]    stamp_q;
  logic [CNT_W-1:0]    mark_now;
  logic [CNT_W-1:0]    open_q;
  logic [CNT_W-1:0]    span_now;
  logic [N_BOUNDS-1:0] breach_vec;

  elc_timebase #(.CNT_W(CNT_W)) u_time (
    .clk(clk), .rst_n(rst_n), .state_chg(state_chg),
    .cyc_now(cyc_now), .stamp_q(stamp_q), .mark_now(mark_now)
  );

  elc_span_meas #(.CNT_W(CNT_W)) u_span (
    .clk(clk), .rst_n(rst_n), .start_mark(start_mark),
    .mark_now(mark_now), .open_q(open_q), .span_now(span_now)
  );

  elc_ladder #(.CNT_W(CNT_W), .N_BOUNDS(N_BOUNDS)) u_ladder (
    .span(span_now), .bounds_flat(bounds_flat), .breach_vec(breach_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flags <= '0;
      delta_out  <= '0;
    end else begin
      fail_flags <= end_mark ? breach_vec : '0;
      if (end_mark) delta_out <= span_now;
    end
  end
endmodule

// File: rtl/elc_checker.sv
module elc_checker #(
  parameter int CNT_W    = 64,
  parameter int N_BOUNDS = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      state_chg,
  input logic                      end_mark,
  input logic [N_BOUNDS*CNT_W-1:0] bounds_flat,
  input logic [N_BOUNDS-1:0]       fail_flags,
  input logic [CNT_W-1:0]          delta_out,
  input logic [CNT_W-1:0]          cyc_now,
  input logic [CNT_W-1:0]          stamp_q
);
  // R2: time base advances by exactly one per clock
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_now == $past(cyc_now) + CNT_W'(1));

  // R3: stamp moves only on a state change
  a_r3_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !state_chg |=> $stable(stamp_q));

  // R6: flags only in the cycle after an end strobe
  a_r6_flags_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    !end_mark |=> fail_flags == '0);

  // R6: delta held between end strobes
  a_r6_delta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !end_mark |=> $stable(delta_out));

  // R5: each flag agrees with the reported delta and the bound in force at the end
  for (genvar gi = 0; gi < N_BOUNDS; gi++) begin : g_chk
    a_r5_bound_breach: assert property (@(posedge clk) disable iff (!rst_n)
      end_mark |=> fail_flags[gi] == (delta_out >= $past(bounds_flat[gi*CNT_W +: CNT_W])));
  end
endmodule

bind elapsed_ladder_check elc_checker #(.CNT_W(CNT_W), .N_BOUNDS(N_BOUNDS)) u_elc_chk (
  .clk(clk), .rst_n(rst_n), .state_chg(state_chg), .end_mark(end_mark),
  .bounds_flat(bounds_flat), .fail_flags(fail_flags), .delta_out(delta_out),
  .cyc_now(cyc_now), .stamp_q(stamp_q)
);

// File: tb/tb_elapsed_ladder_check.sv
module tb_elapsed_ladder_check;
  localparam int W = 16;
  localparam int N = 10;

  typedef struct {
    logic [W-1:0] d;
    logic [N-1:0] f;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic state_chg = 1'b0, start_mark = 1'b0, end_mark = 1'b0;
  logic [N*W-1:0] bounds_flat;
  logic [N-1:0]   fail_flags;
  logic [W-1:0]   delta_out;

  logic [W-1:0] bnd [N];
  exp_t         sb_q[$];
  longint       cyc = 0;
  logic [W-1:0] entry_v = '0, start_v = '0, last_delta = '0;
  logic         end_seen = 1'b0;
  int           total = 0, bad = 0;
  bit           done = 0;

  elapsed_ladder_check #(.CNT_W(W), .N_BOUNDS(N)) dut (
    .clk(clk), .rst_n(rst_n), .state_chg(state_chg), .start_mark(start_mark),
    .end_mark(end_mark), .bounds_flat(bounds_flat), .fail_flags(fail_flags),
    .delta_out(delta_out)
  );

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) bounds_flat[i*W +: W] = bnd[i];
  end

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    end_seen <= end_mark;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (end_seen) begin
        exp_t e;
        total++;
        if (sb_q.size() == 0) begin
          bad++;
          $display("FAIL R6: result appeared with no expected item, delta=%0d", delta_out);
        end else begin
          e = sb_q.pop_front();
          if (delta_out !== e.d || fail_flags !== e.f) begin
            bad++;
            $display("FAIL %s: delta=%0d flags=%b expected delta=%0d flags=%b",
                     e.tag, delta_out, fail_flags, e.d, e.f);
          end
          last_delta = e.d;
        end
      end else begin
        total++;
        if (fail_flags !== '0 || delta_out !== last_delta) begin
          bad++;
          $display("FAIL R6: quiet cycle flags=%b delta=%0d expected flags=0 delta=%0d",
                   fail_flags, delta_out, last_delta);
        end
      end
    end
  end

  task automatic step(input bit chg, input bit st, input bit en, input string tag);
    logic [W-1:0] mk;
    exp_t e;
    state_chg = chg; start_mark = st; end_mark = en;
    if (chg) entry_v = W'(cyc);
    mk = entry_v;
    if (en) begin
      e.d = mk - start_v;
      for (int i = 0; i < N; i++) e.f[i] = (e.d >= bnd[i]);
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (st) start_v = mk;
    @(negedge clk);
    state_chg = 1'b0; start_mark = 1'b0; end_mark = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, "");
  endtask

  task automatic measure(input int d, input string tag);
    step(1, 1, 0, tag);
    idle(d - 1);
    step(1, 0, 1, tag);
  endtask

  initial begin
    bnd[0] = 1024; bnd[1] = 640; bnd[2] = 576; bnd[3] = 544; bnd[4] = 528;
    bnd[5] = 520;  bnd[6] = 516; bnd[7] = 514; bnd[8] = 513; bnd[9] = 512;
    repeat (3) @(negedge clk);
    total++;
    if (fail_flags !== '0 || delta_out !== '0) begin
      bad++;
      $display("FAIL R1: in reset flags=%b delta=%0d expected 0 0", fail_flags, delta_out);
    end
    rst_n = 1'b1;
    total++;
    if (fail_flags !== '0 || delta_out !== '0) begin
      bad++;
      $display("FAIL R1: after release flags=%b delta=%0d expected 0 0", fail_flags, delta_out);
    end
    // R2: first start at counter 0, end 700 cycles later; R5 bits 9..1 violated
    step(1, 1, 0, "R2");
    idle(699);
    step(1, 0, 1, "R2");
    idle(3);
    // R5: ladder edges
    measure(515, "R5");
    measure(1023, "R5");
    measure(1024, "R5");
    measure(512, "R5");
    measure(511, "R5");
    measure(1, "R5");
    // R3: marks inside long states read the entry time
    step(1, 0, 0, "R3");
    idle(10);
    step(0, 1, 0, "R3");
    idle(600);
    step(1, 0, 0, "R3");
    idle(30);
    step(0, 0, 1, "R3");
    idle(2);
    // R7: start and end together
    step(1, 1, 0, "R7");
    idle(99);
    step(1, 1, 1, "R7");
    idle(49);
    step(1, 0, 1, "R7");
    idle(2);
    // R5: a changed bound takes effect
    bnd[0] = 3;
    measure(3, "R5");
    measure(2, "R5");
    bnd[0] = 1024;
    idle(2);
    // R4: measurement across counter wrap
    while (cyc < (longint'(1) << W) - 300) step(0, 0, 0, "");
    measure(600, "R4");
    idle(3);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R6: %0d results missing, expected 0", sb_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule